// File: doc/BRIEF.md
# Clock Ratio Detector and Resynchronizer

This block sits between the serial audio input and the sample-rate logic of a converter. It watches the word clock (one rising edge per sample) with the system clock and decides whether the system clock runs at 256 or 384 times the sample rate. It runs an internal sample-phase counter at that ratio and keeps the counter aligned with the word clock. The rest of the datapath uses the counter's zero point as its sample instant.

After reset the block holds a mute request for an initialisation interval. It then acquires the ratio from two matching word-clock periods and aligns its phase. The phase may drift from the word clock, and small drift is left alone. The block realigns only when the drift exceeds a tolerance of six bit-clock periods, with the bit-clock period measured in system clocks. While it is acquiring or realigning, the mute request tells the output stage to sit at midscale. The mute request stays high for one further word-clock period after each alignment. The word clock and bit clock are expected to be already synchronous to the system clock.

Top module: `clk_ratio_sync`

## Requirements
- R1: While `rstN` is low, `mute` is 1, `ratio384` is 0, `phase` is 0 and `sampleTick` is 1.
- R2: After reset is released, `mute` stays 1 for at least 1024 system-clock cycles whatever the inputs do, and no ratio is acquired during those cycles.
- R3: A word-clock period is the number of system clocks from one rising word-clock edge to the next. A period from 248 to 264 is classed as the 256 ratio and a period from 376 to 392 as the 384 ratio. Any other period is unrecognised. A ratio is acquired only when two consecutive periods fall in the same class. `ratio384` is 1 for the 384 ratio and 0 for the 256 ratio.
- R4: After an acquisition or a realignment, `mute` stays 1 until the next rising word-clock edge. If that edge closes a period that matches the held ratio, `mute` is 0 from the cycle after that edge.
- R5: `phase` counts 0 to L-1 and wraps, where L is 256 or 384 as held. An alignment makes `phase` read 0 in the cycle of the next rising word-clock edge when the period is exact. `sampleTick` is 1 exactly when `phase` is 0.
- R6: While unmuted, a period that is unrecognised or that matches the other ratio sets `mute` to 1. `ratio384` keeps its old value until a new ratio is acquired under R3.
- R7: While unmuted, at each rising word-clock edge the phase error is the circular distance of `phase` from 0 modulo L. The tolerance is 6 times the latest bit-clock period in system clocks. An error at or below the tolerance changes nothing. An error above it realigns the phase and starts the mute period of R4.
- R8: `ratio384` changes only in a cycle in which `mute` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordClk | input | 1 | Sample-rate word clock, synchronous to clk |
| bitClk | input | 1 | Serial bit clock, synchronous to clk |
| ratio384 | output | 1 | Held ratio: 1 = 384x, 0 = 256x |
| phase | output | $clog2(RATIO_HI) | Sample-phase counter |
| sampleTick | output | 1 | High when the phase counter is 0 |
| mute | output | 1 | Request to force the output to midscale |

## Verification
The bench aims at the edges of the period window: 392 must lock, while 393 and 247 must never lock. A design with an off-by-one window would either lock on those bad periods or refuse the good one. It drifts the word clock by 4 clocks per period in both directions against a tolerance of 24. A design that used the wrong tolerance, or measured error in only one direction, would realign a period early or late or never realign at all. This shows up as a misplaced mute pulse and a wrong captured phase. A lock that is broken by an unrecognised period and then followed by a change of ratio checks three things: the old ratio must be held while muted, two good periods are needed before the new ratio is taken, and the init interval cannot be shortened without the first lock moving to an earlier frame.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_256  = 2'd1,
    CLS_384  = 2'd2
  } ratioCls_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic align;       // restart phase counter at this word-clock edge
    logic latchRatio;  // load a new ratio
    logic sel384;      // ratio to load
  } dpCmd_t;

endpackage

// File: rtl/clk_ratio_dp.sv
module clk_ratio_dp
  import clk_ratio_pkg::*;
#(
  parameter int RATIO_LO  = 256,
  parameter int RATIO_HI  = 384,
  parameter int RATIO_TOL = 8,
  parameter int TOL_BITS  = 6,
  parameter int PER_W     = 10,
  parameter int BIT_W     = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wordClk,
  input  logic                        bitClk,
  input  dpCmd_t                      cmd,
  output logic                        wcRise,
  output ratioCls_t                   periodCls,
  output logic                        phaseBad,
  output logic                        sel384,
  output logic [$clog2(RATIO_HI)-1:0] phaseCnt
);
  localparam int PH_W = $clog2(RATIO_HI);

  logic             wcPrev, bcPrev, bcRise;
  logic [PER_W-1:0] periodCnt;
  logic [BIT_W-1:0] bitCnt, bitPer;
  int               measured, ratioLen, phaseInt, phaseErr, tolClk;

  assign wcRise = wordClk & ~wcPrev;
  assign bcRise = bitClk & ~bcPrev;

  function automatic ratioCls_t classify(input int m);
    if (m >= RATIO_LO - RATIO_TOL && m <= RATIO_LO + RATIO_TOL) return CLS_256;
    if (m >= RATIO_HI - RATIO_TOL && m <= RATIO_HI + RATIO_TOL) return CLS_384;
    return CLS_NONE;
  endfunction

  assign measured  = int'(periodCnt) + 1;
  assign periodCls = classify(measured);

  // Circular distance of the phase counter from zero
  assign ratioLen = sel384 ? RATIO_HI : RATIO_LO;
  assign phaseInt = int'(phaseCnt);
  assign phaseErr = (2 * phaseInt < ratioLen) ? phaseInt : ratioLen - phaseInt;
  assign tolClk   = TOL_BITS * int'(bitPer);
  assign phaseBad = phaseErr > tolClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wcPrev    <= 1'b0;
      bcPrev    <= 1'b0;
      periodCnt <= '0;
      bitCnt    <= '0;
      bitPer    <= '0;
    end else begin
      wcPrev <= wordClk;
      bcPrev <= bitClk;
      if (wcRise)               periodCnt <= '0;
      else if (periodCnt != '1) periodCnt <= periodCnt + 1'b1;
      if (bcRise) begin
        bitCnt <= '0;
        bitPer <= (bitCnt == '1) ? bitCnt : bitCnt + 1'b1;
      end else if (bitCnt != '1) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sel384   <= 1'b0;
      phaseCnt <= '0;
    end else begin
      if (cmd.latchRatio) sel384 <= cmd.sel384;
      if (cmd.align)                      phaseCnt <= PH_W'(1);
      else if (phaseInt == ratioLen - 1)  phaseCnt <= '0;
      else                                phaseCnt <= phaseCnt + 1'b1;
    end
  end

  assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    phaseInt < ratioLen);

  assert_latch_on_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.latchRatio |-> wcRise);

endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import clk_ratio_pkg::*;
#(
  parameter int INIT_CYCLES = 1024
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wcRise,
  input  ratioCls_t periodCls,
  input  logic      phaseBad,
  input  logic      sel384,
  output dpCmd_t    cmd,
  output logic      mute
);
  localparam int INIT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;

  typedef enum logic [1:0] {ST_INIT, ST_ACQ, ST_HOLD, ST_LOCK} syncState_t;

  syncState_t        state, stateNext;
  ratioCls_t         prevCls, heldCls;
  logic [INIT_W-1:0] initCnt;

  assign heldCls = sel384 ? CLS_384 : CLS_256;
  assign mute    = (state != ST_LOCK);

  always_comb begin
    stateNext = state;
    cmd       = '0;
    case (state)
      ST_INIT: if (int'(initCnt) == INIT_CYCLES - 1) stateNext = ST_ACQ;
      ST_ACQ: begin
        if (wcRise && periodCls != CLS_NONE && periodCls == prevCls) begin
          cmd.latchRatio = 1'b1;
          cmd.sel384     = (periodCls == CLS_384);
          cmd.align      = 1'b1;
          stateNext      = ST_HOLD;
        end
      end
      ST_HOLD: if (wcRise) stateNext = (periodCls == heldCls) ? ST_LOCK : ST_ACQ;
      ST_LOCK: begin
        if (wcRise) begin
          if (periodCls != heldCls) begin
            stateNext = ST_ACQ;
          end else if (phaseBad) begin
            cmd.align = 1'b1;
            stateNext = ST_HOLD;
          end
        end
      end
      default: stateNext = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_INIT;
      prevCls <= CLS_NONE;
      initCnt <= '0;
    end else begin
      state <= stateNext;
      if (wcRise) prevCls <= periodCls;
      if (state == ST_INIT) initCnt <= initCnt + 1'b1;
    end
  end

  assert_mute_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mute) |-> $past(wcRise));

  assert_ratio_change_muted_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sel384 != $past(sel384)) |-> $past(mute));

endmodule

// File: rtl/clk_ratio_sync.sv
module clk_ratio_sync
  import clk_ratio_pkg::*;
#(
  parameter int RATIO_LO    = 256,
  parameter int RATIO_HI    = 384,
  parameter int RATIO_TOL   = 8,
  parameter int TOL_BITS    = 6,
  parameter int INIT_CYCLES = 1024,
  parameter int PER_W       = 10,
  parameter int BIT_W       = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wordClk,
  input  logic                        bitClk,
  output logic                        ratio384,
  output logic [$clog2(RATIO_HI)-1:0] phase,
  output logic                        sampleTick,
  output logic                        mute
);
  dpCmd_t    cmd;
  logic      wcRise, phaseBad;
  ratioCls_t periodCls;

  clk_ratio_dp #(
    .RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI), .RATIO_TOL(RATIO_TOL),
    .TOL_BITS(TOL_BITS), .PER_W(PER_W), .BIT_W(BIT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .wordClk(wordClk), .bitClk(bitClk), .cmd(cmd),
    .wcRise(wcRise), .periodCls(periodCls), .phaseBad(phaseBad),
    .sel384(ratio384), .phaseCnt(phase)
  );

  clk_ratio_ctrl #(.INIT_CYCLES(INIT_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wcRise(wcRise), .periodCls(periodCls),
    .phaseBad(phaseBad), .sel384(ratio384), .cmd(cmd), .mute(mute)
  );

  assign sampleTick = (phase == '0);

endmodule

// File: tb/clk_ratio_sync_tb.sv
`timescale 1ns/1ps
module clk_ratio_sync_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wordClk = 1'b0;
  logic bitClk = 1'b0;
  logic ratio384, sampleTick, mute;
  logic [8:0] phase;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic muteAt [0:15];
  logic tickAt [0:15];
  logic ratioAt[0:15];
  int   phaseAt[0:15];

  // {period, bit period, expected ratio384, first frame seen unmuted (8 = never)}
  localparam int NVEC = 7;
  localparam int vecTab [NVEC][4] = '{
    '{256, 4, 0, 6}, '{384, 6, 1, 5}, '{256, 8, 0, 6}, '{384, 12, 1, 5},
    '{392, 8, 1, 5}, '{393, 8, 0, 8}, '{247, 4, 0, 8}
  };

  always #2.5 clk = ~clk;

  clk_ratio_sync dut_i (
    .clk(clk), .rstN(rstN), .wordClk(wordClk), .bitClk(bitClk),
    .ratio384(ratio384), .phase(phase), .sampleTick(sampleTick), .mute(mute)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0; wordClk = 1'b0; bitClk = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check("R1", "mute in reset", int'(mute), 1);
    check("R1", "ratio384 in reset", int'(ratio384), 0);
    check("R1", "phase in reset", int'(phase), 0);
    check("R1", "sampleTick in reset", int'(sampleTick), 1);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // One word-clock period of n system clocks; records outputs at the rising edge cycle
  task automatic runFrame(input int idx, input int n, input int p);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wordClk = (i < n / 2);
      bitClk  = ((i % p) < p / 2);
      if (i == 0) begin
        #1;
        muteAt[idx]  = mute;
        tickAt[idx]  = sampleTick;
        ratioAt[idx] = ratio384;
        phaseAt[idx] = int'(phase);
      end
    end
  endtask

  initial begin
    #950000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Vector table: acquisition, init interval, window edges
    for (int v = 0; v < NVEC; v++) begin
      resetDut();
      for (int f = 0; f < 8; f++) runFrame(f, vecTab[v][0], vecTab[v][1]);
      for (int f = 0; f < 8; f++) begin
        if (f < vecTab[v][3])
          check(f == 4 ? "R2" : "R3", $sformatf("vec %0d mute frame %0d", v, f), int'(muteAt[f]), 1);
        else
          check("R4", $sformatf("vec %0d mute frame %0d", v, f), int'(muteAt[f]), 0);
      end
      check("R3", $sformatf("vec %0d ratio384", v), int'(ratioAt[7]), vecTab[v][2]);
      if (vecTab[v][0] == 256 || vecTab[v][0] == 384) begin
        check("R5", $sformatf("vec %0d tick at rise", v), int'(tickAt[7]), 1);
        check("R5", $sformatf("vec %0d phase at rise", v), phaseAt[7], 0);
      end
    end

    // Slow drift: +4 clocks per period, tolerance 24
    resetDut();
    for (int f = 0; f < 14; f++) runFrame(f, 260, 4);
    check("R7", "drift+ phase f10", phaseAt[10], 24);
    check("R7", "drift+ error at tolerance keeps lock", int'(muteAt[11]), 0);
    check("R7", "drift+ phase f11", phaseAt[11], 28);
    check("R7", "drift+ realign mutes", int'(muteAt[12]), 1);
    check("R7", "drift+ phase after realign", phaseAt[12], 4);
    check("R4", "drift+ unmute after one period", int'(muteAt[13]), 0);

    // Slow drift the other way: -4 clocks per period
    resetDut();
    for (int f = 0; f < 15; f++) runFrame(f, 252, 4);
    check("R7", "drift- phase f11", phaseAt[11], 232);
    check("R7", "drift- phase f12", phaseAt[12], 228);
    check("R7", "drift- error at tolerance keeps lock", int'(muteAt[12]), 0);
    check("R7", "drift- realign mutes", int'(muteAt[13]), 1);
    check("R7", "drift- phase after realign", phaseAt[13], 252);
    check("R4", "drift- unmute after one period", int'(muteAt[14]), 0);

    // Lock at 384, one unrecognised period, then switch to 256
    resetDut();
    for (int f = 0; f < 6; f++) runFrame(f, 384, 8);
    runFrame(6, 320, 8);
    for (int f = 7; f < 12; f++) runFrame(f, 256, 8);
    check("R6", "locked before bad period", int'(muteAt[7]), 0);
    check("R6", "bad period mutes", int'(muteAt[8]), 1);
    check("R6", "ratio held after bad period", int'(ratioAt[8]), 1);
    check("R3", "one good period does not acquire", int'(ratioAt[9]), 1);
    check("R8", "new ratio taken while muted", int'(ratioAt[10]), 0);
    check("R4", "still muted one period after acquire", int'(muteAt[10]), 1);
    check("R4", "unmuted after new lock", int'(muteAt[11]), 0);
    check("R5", "tick aligned at new ratio", int'(tickAt[11]), 1);
    check("R5", "phase aligned at new ratio", phaseAt[11], 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule